// File: doc/BRIEF.md
# Address Region Attribute Lookup

This block maps a physical address onto the memory attribute byte that governs it. Software programs up to eight address windows, each with its own attribute byte, an enable, and inclusive lower and upper page bounds on a 4 KB page grid. A separate default register supplies the attribute for any address that no enabled window covers. The host side is a plain 64-bit register write port with a window index, a select for the default register, and a combinational read-back port.

Each clock the block compares the presented address against every window in parallel. When several windows match, the lowest index wins. It registers the selected attribute and a hit flag, so the answer appears one clock after the address. Attribute bits carry this meaning: bit 0 cache disabled, bit 1 write-allocate, bit 2 write-protect, bit 3 write-through, bit 4 write-combine, bit 5 write-serialize. Bits 7:6 are stored and passed through unchanged.

Top module: `rgn_attr_lookup`

## Requirements
- R1: While reset is asserted and after it, all windows are disabled and the default attribute is 8'h01. The outputs read attr_o = 8'h01 and hit_o = 0.
- R2: A write with cfg_we = 1 and cfg_dflt = 0 stores cfg_wdata into window cfg_idx. The layout is attribute in bits 7:0, enable in bit 8, start page in bits 31:12, top page in bits 63:44. Read-back of that window returns the stored value with bits 11:9 and 43:32 as zero.
- R3: A write with cfg_we = 1 and cfg_dflt = 1 stores cfg_wdata[7:0] as the default attribute. Read-back with rd_dflt = 1 returns it zero-extended to 64 bits.
- R4: An enabled window matches when start page ≤ address[31:12] ≤ top page. Both bounds are inclusive. On a match, attr_o is that window's attribute and hit_o = 1.
- R5: A window whose enable bit is 0 never matches.
- R6: A window whose top page is below its start page never matches.
- R7: When several enabled windows match, the attribute of the lowest-indexed one is returned.
- R8: When no window matches, attr_o is the default attribute and hit_o = 0.
- R9: Address bits 11:0 and the reserved write bits 11:9 and 43:32 have no effect on the lookup result.
- R10: The outputs after a rising edge reflect the address sampled at that edge, looked up against the configuration held before that edge. A write at the same edge affects only later lookups.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_dflt | input | 1 | Write targets the default attribute register |
| cfg_idx | input | 3 | Window index for a write |
| cfg_wdata | input | 64 | Write data |
| rd_dflt | input | 1 | Read-back selects the default register |
| rd_idx | input | 3 | Window index for read-back |
| rd_data | output | 64 | Combinational read-back data |
| lk_addr | input | 32 | Physical address to look up |
| attr_o | output | 8 | Registered attribute result |
| hit_o | output | 1 | Registered window-hit flag |

## Verification
A lookup result is due exactly one rising edge after the address is driven. The bench drives each address on a falling edge, waits for the next rising edge, and samples attr_o and hit_o on the following falling edge. Register writes take effect at the rising edge that captures them. The bench checks the combinational read-back on the falling edge after the write. It also runs one test that writes a window and presents a lookup at the same edge, to confirm that the old configuration answers that lookup and the new one answers the next.

// File: rtl/rgn_attr_pkg.sv
package rgn_attr_pkg;
    localparam int ADDR_W     = 32;
    localparam int PAGE_SHIFT = 12;
    localparam int PAGE_W     = ADDR_W - PAGE_SHIFT;
    localparam int ATTR_W     = 8;
    localparam int REG_W      = 64;
    localparam int EN_BIT     = 8;
    localparam int START_LSB  = 12;
    localparam int TOP_LSB    = 44;

    typedef struct packed {
        logic [PAGE_W-1:0] top;
        logic [PAGE_W-1:0] start;
        logic              en;
        logic [ATTR_W-1:0] attr;
    } rng_cfg_t;

    function automatic rng_cfg_t rng_unpack(input logic [REG_W-1:0] w);
        rng_cfg_t c;
        c.attr  = w[ATTR_W-1:0];
        c.en    = w[EN_BIT];
        c.start = w[START_LSB +: PAGE_W];
        c.top   = w[TOP_LSB +: PAGE_W];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] rng_pack(input rng_cfg_t c);
        logic [REG_W-1:0] w;
        w = '0;
        w[ATTR_W-1:0]          = c.attr;
        w[EN_BIT]              = c.en;
        w[START_LSB +: PAGE_W] = c.start;
        w[TOP_LSB +: PAGE_W]   = c.top;
        return w;
    endfunction
endpackage

// File: rtl/rgn_attr_regs.sv
module rgn_attr_regs
    import rgn_attr_pkg::*;
#(
    parameter int                N_RANGES   = 8,
    parameter int                IDX_W      = $clog2(N_RANGES),
    parameter logic [ATTR_W-1:0] DFLT_RESET = 8'h01
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             we,
    input  logic                             dflt_sel,
    input  logic [IDX_W-1:0]                 idx,
    input  logic [REG_W-1:0]                 wdata,
    input  logic                             rd_dflt,
    input  logic [IDX_W-1:0]                 rd_idx,
    output logic [REG_W-1:0]                 rd_data,
    output rng_cfg_t [N_RANGES-1:0]          cfg_q,
    output logic [ATTR_W-1:0]                dflt_q
);
    logic unused_rsv;
    assign unused_rsv = ^{wdata[START_LSB-1:EN_BIT+1], wdata[TOP_LSB-1:START_LSB+PAGE_W]};

    for (genvar i = 0; i < N_RANGES; i++) begin : g_rng
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cfg_q[i] <= '0;
            end else if (we && !dflt_sel && (idx == IDX_W'(i))) begin
                cfg_q[i] <= rng_unpack(wdata);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dflt_q <= DFLT_RESET;
        end else if (we && dflt_sel) begin
            dflt_q <= wdata[ATTR_W-1:0];
        end
    end

    always_comb begin
        if (rd_dflt) begin
            rd_data = {{(REG_W-ATTR_W){1'b0}}, dflt_q};
        end else begin
            rd_data = rng_pack(cfg_q[rd_idx]);
        end
    end
endmodule

// File: rtl/rgn_attr_match.sv
module rgn_attr_match
    import rgn_attr_pkg::*;
(
    input  rng_cfg_t          cfg,
    input  logic [PAGE_W-1:0] page,
    output logic              hit
);
    logic above_start;
    logic below_top;

    assign above_start = (page >= cfg.start);
    assign below_top   = (page <= cfg.top);
    assign hit         = cfg.en && above_start && below_top;
endmodule

// File: rtl/rgn_attr_prio.sv
module rgn_attr_prio
    import rgn_attr_pkg::*;
#(
    parameter int N_RANGES = 8
) (
    input  logic [N_RANGES-1:0]             match,
    input  logic [N_RANGES-1:0][ATTR_W-1:0] attrs,
    input  logic [ATTR_W-1:0]               dflt,
    output logic [ATTR_W-1:0]               attr,
    output logic                            hit
);
    always_comb begin
        attr = dflt;
        hit  = 1'b0;
        for (int i = N_RANGES - 1; i >= 0; i--) begin
            if (match[i]) begin
                attr = attrs[i];
                hit  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/rgn_attr_lookup.sv
module rgn_attr_lookup
    import rgn_attr_pkg::*;
#(
    parameter int                N_RANGES   = 8,
    parameter int                IDX_W      = $clog2(N_RANGES),
    parameter logic [ATTR_W-1:0] DFLT_RESET = 8'h01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_dflt,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [REG_W-1:0]  cfg_wdata,
    input  logic              rd_dflt,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [REG_W-1:0]  rd_data,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic [ATTR_W-1:0] attr_o,
    output logic              hit_o
);
    rng_cfg_t [N_RANGES-1:0]          cfg_q;
    logic [ATTR_W-1:0]                dflt_attr;
    logic [N_RANGES-1:0]              match_vec;
    logic [N_RANGES-1:0]              en_vec;
    logic [N_RANGES-1:0][ATTR_W-1:0]  attr_vec;
    logic [PAGE_W-1:0]                page;
    logic [ATTR_W-1:0]                sel_attr;
    logic                             sel_hit;
    logic                             unused_offset;

    assign page          = lk_addr[ADDR_W-1:PAGE_SHIFT];
    assign unused_offset = ^lk_addr[PAGE_SHIFT-1:0];

    rgn_attr_regs #(
        .N_RANGES   (N_RANGES),
        .IDX_W      (IDX_W),
        .DFLT_RESET (DFLT_RESET)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .dflt_sel (cfg_dflt),
        .idx      (cfg_idx),
        .wdata    (cfg_wdata),
        .rd_dflt  (rd_dflt),
        .rd_idx   (rd_idx),
        .rd_data  (rd_data),
        .cfg_q    (cfg_q),
        .dflt_q   (dflt_attr)
    );

    for (genvar i = 0; i < N_RANGES; i++) begin : g_cmp
        assign en_vec[i]   = cfg_q[i].en;
        assign attr_vec[i] = cfg_q[i].attr;
        rgn_attr_match u_match (
            .cfg  (cfg_q[i]),
            .page (page),
            .hit  (match_vec[i])
        );
    end

    rgn_attr_prio #(
        .N_RANGES (N_RANGES)
    ) u_prio (
        .match (match_vec),
        .attrs (attr_vec),
        .dflt  (dflt_attr),
        .attr  (sel_attr),
        .hit   (sel_hit)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            attr_o <= DFLT_RESET;
            hit_o  <= 1'b0;
        end else begin
            attr_o <= sel_attr;
            hit_o  <= sel_hit;
        end
    end
endmodule

// File: rtl/rgn_attr_lookup_chk.sv
module rgn_attr_lookup_chk
    import rgn_attr_pkg::*;
#(
    parameter int                N_RANGES   = 8,
    parameter logic [ATTR_W-1:0] DFLT_RESET = 8'h01
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cfg_we,
    input logic                cfg_dflt,
    input logic [REG_W-1:0]    cfg_wdata,
    input logic [N_RANGES-1:0] en_vec,
    input logic [N_RANGES-1:0] match_vec,
    input logic [ATTR_W-1:0]   dflt_attr,
    input logic [ATTR_W-1:0]   attr_o,
    input logic                hit_o
);
    assert_reset_outputs_R1: assert property (@(posedge clk)
        !rst_n |=> (!hit_o && attr_o == DFLT_RESET));

    assert_dflt_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_dflt) |=> (dflt_attr == $past(cfg_wdata[ATTR_W-1:0])));

    assert_hit_needs_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> $past(|match_vec));

    assert_hit_needs_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> $past(|en_vec));

    assert_miss_gives_default_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_o |-> (attr_o == $past(dflt_attr)));
endmodule

bind rgn_attr_lookup rgn_attr_lookup_chk #(
    .N_RANGES   (N_RANGES),
    .DFLT_RESET (DFLT_RESET)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_dflt  (cfg_dflt),
    .cfg_wdata (cfg_wdata),
    .en_vec    (en_vec),
    .match_vec (match_vec),
    .dflt_attr (dflt_attr),
    .attr_o    (attr_o),
    .hit_o     (hit_o)
);

// File: tb/rgn_attr_lookup_tb.sv
module rgn_attr_lookup_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_dflt = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic [63:0] cfg_wdata = '0;
    logic        rd_dflt = 1'b0;
    logic [2:0]  rd_idx = '0;
    logic [63:0] rd_data;
    logic [31:0] lk_addr = '0;
    logic [7:0]  attr_o;
    logic        hit_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rgn_attr_lookup u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_dflt(cfg_dflt),
        .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .rd_dflt(rd_dflt),
        .rd_idx(rd_idx), .rd_data(rd_data), .lk_addr(lk_addr),
        .attr_o(attr_o), .hit_o(hit_o)
    );

    // window encoding: top[63:44], start[31:12], enable[8], attr[7:0]
    function automatic logic [63:0] enc(input logic [19:0] top, input logic [19:0] start,
                                        input logic en, input logic [7:0] attr);
        return {top, 12'h000, start, 3'b000, en, attr};
    endfunction

    // {addr, expected attr, expected hit}
    localparam logic [40:0] VEC [14] = '{
        {32'h0010_0000, 8'h11, 1'b1},   // R4 start inclusive
        {32'h001F_FFFF, 8'h11, 1'b1},   // R4 top inclusive
        {32'h0018_0000, 8'h11, 1'b1},   // R7 overlap, window 0 wins
        {32'h0020_0000, 8'h22, 1'b1},   // R4
        {32'h0030_0FFF, 8'h22, 1'b1},   // R4 top inclusive
        {32'h0030_1000, 8'h19, 1'b0},   // R8 just past top
        {32'h000F_FFFF, 8'h19, 1'b0},   // R8 just below start
        {32'h0040_0000, 8'h19, 1'b0},   // R5 disabled window
        {32'h005F_F000, 8'h19, 1'b0},   // R6 inverted window
        {32'h0060_0000, 8'h19, 1'b0},   // R6 inverted window
        {32'h0080_0ABC, 8'h08, 1'b1},   // R9 offset ignored
        {32'h0080_1000, 8'h19, 1'b0},   // R8
        {32'hFFFF_FFFF, 8'h2A, 1'b1},   // R4 highest page
        {32'hFFFF_0000, 8'h2A, 1'b1}    // R4
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic dflt, input logic [2:0] idx, input logic [63:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_dflt = dflt; cfg_idx = idx; cfg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0; cfg_dflt = 1'b0;
    endtask

    task automatic look(input string req, input logic [31:0] a,
                        input logic [7:0] ea, input logic eh);
        @(negedge clk);
        lk_addr = a;
        @(posedge clk);
        @(negedge clk);
        chk(req, {55'd0, hit_o, attr_o}, {55'd0, eh, ea});
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset outputs", {55'd0, hit_o, attr_o}, {55'd0, 1'b0, 8'h01});
        rst_n = 1'b1;
        look("R1 no windows after reset", 32'h0010_0000, 8'h01, 1'b0);
        rd_dflt = 1'b1;
        #1 chk("R1 default readback", rd_data, 64'h01);
        rd_dflt = 1'b0;

        wr(1'b0, 3'd0, enc(20'h001FF, 20'h00100, 1'b1, 8'h11));
        wr(1'b0, 3'd1, enc(20'h00300, 20'h00180, 1'b1, 8'h22));
        wr(1'b0, 3'd2, enc(20'h004FF, 20'h00400, 1'b0, 8'h33));
        wr(1'b0, 3'd3, enc(20'h005FF, 20'h00600, 1'b1, 8'h44));
        // window 4 written with reserved bits set (R9)
        wr(1'b0, 3'd4, enc(20'h00800, 20'h00800, 1'b1, 8'h08) | 64'h0000_0FFF_0000_0E00);
        wr(1'b0, 3'd7, enc(20'hFFFFF, 20'hFFFF0, 1'b1, 8'h2A));
        wr(1'b1, 3'd0, 64'hFFFF_FFFF_FFFF_FF19);

        rd_idx = 3'd4;
        #1 chk("R2 readback reserved zero", rd_data, enc(20'h00800, 20'h00800, 1'b1, 8'h08));
        rd_idx = 3'd1;
        #1 chk("R2 readback window 1", rd_data, enc(20'h00300, 20'h00180, 1'b1, 8'h22));
        rd_dflt = 1'b1;
        #1 chk("R3 default readback", rd_data, 64'h19);
        rd_dflt = 1'b0;

        for (int i = 0; i < 14; i++) begin
            look("R4-table", VEC[i][40:9], VEC[i][8:1], VEC[i][0]);
        end

        // R5: enabling window 2 makes it match
        wr(1'b0, 3'd2, enc(20'h004FF, 20'h00400, 1'b1, 8'h33));
        look("R5 enabled now matches", 32'h0040_0000, 8'h33, 1'b1);

        // R7: window 1 overlapping window 2, lower index wins
        wr(1'b0, 3'd1, enc(20'h00500, 20'h00180, 1'b1, 8'h22));
        look("R7 lower index wins", 32'h0040_0800, 8'h22, 1'b1);

        // R10: back-to-back addresses, one cycle each
        @(negedge clk);
        lk_addr = 32'h0010_0000;
        @(negedge clk);
        chk("R10 first of pair", {55'd0, hit_o, attr_o}, {55'd0, 1'b1, 8'h11});
        lk_addr = 32'h0080_0000;
        @(negedge clk);
        chk("R10 second of pair", {55'd0, hit_o, attr_o}, {55'd0, 1'b1, 8'h08});

        // R10: write and lookup at the same edge use the old configuration
        @(negedge clk);
        lk_addr = 32'h0010_0000;
        cfg_we = 1'b1; cfg_dflt = 1'b0; cfg_idx = 3'd0;
        cfg_wdata = enc(20'h001FF, 20'h00100, 1'b0, 8'h11);
        @(negedge clk);
        cfg_we = 1'b0;
        chk("R10 same-edge write uses old config", {55'd0, hit_o, attr_o}, {55'd0, 1'b1, 8'h11});
        @(negedge clk);
        chk("R10 next lookup uses new config", {55'd0, hit_o, attr_o}, {55'd0, 1'b0, 8'h19});

        // R8: new default value shows on miss
        wr(1'b1, 3'd0, 64'h0000_0000_0000_0005);
        look("R8 updated default", 32'h0070_0000, 8'h05, 1'b0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule